// File: doc/BRIEF.md
# Host-Side Burst Initiation and Pause Controller

This block is the host end of a source-synchronous data-in burst. A command is opened with a start pulse. While it is open, the block waits for the device to raise its request line. It then grants the burst by pulling its active-low acknowledge. One cycle later it arms the receive path: it releases the stop line and pulls its active-low ready line. The data strobe from the device is sampled through a synchronizer. Each change of the strobe, rising or falling, delivers one 16-bit word on a valid/data output pair.

From the moment the path is armed until the first word arrives, the stop and ready outputs are frozen, and pause or end requests from the local side have no effect. After that, the local side may pause the burst by dropping ready. Words that are still in flight are then accepted up to an allowance set by the transfer mode, and anything beyond that allowance is dropped and flagged. A burst ends when the local side asks for it or when the device withdraws its request. Stop is raised first and acknowledge is released one cycle later. The block then waits for a new request or for the end of the command.

During a command the address lines are forced to zero, or held at the value captured at command start when the zero-address variant is not selected. The chip selects are negated while a burst is granted. Outside a command both sets of lines follow the register-access inputs.

Top module: `burst_init_ctrl`

## Requirements
- R1: During and after reset, with no command open: ack_n_o=1, stop_o=1, rdy_n_o=1, word_valid_o=0, overrun_o=0, and addr_o/sel_n_o equal pio_addr_i/pio_sel_n_i.
- R2: While a command is open and dev_req_i is low, ack_n_o stays 1. ack_n_o goes to 0 only in the cycle after dev_req_i was sampled high, and stop_o=1 and rdy_n_o=1 in that cycle.
- R3: In the cycle after ack_n_o falls, stop_o becomes 0 and rdy_n_o becomes 0 together.
- R4: From arming until the first word is delivered, stop_o and rdy_n_o stay 0 even if pause_i or end_i is asserted.
- R5: Every change of strobe_i (both directions) delivers exactly one word on word_o with word_valid_o=1, three clock edges after the change, in arrival order.
- R6: pause_i high during transfer sets rdy_n_o to 1 in the next cycle. pause_i low again returns rdy_n_o to 0 in the next cycle, while stop_o stays 0.
- R7: While paused, the block accepts at most 2 words when mode_i (captured at command start) is 0 to 2, and at most 3 words for higher modes. The next word is dropped and sets overrun_o, which stays 1 until the next command start clears it.
- R8: end_i high, or dev_req_i low, during transfer or pause raises stop_o in the next cycle while ack_n_o stays 0. ack_n_o returns to 1 and rdy_n_o to 1 one cycle later.
- R9: While ack_n_o is 0, sel_n_o is all ones. Otherwise, sel_n_o follows pio_sel_n_i.
- R10: From the cycle after cmd_go_i until the command ends, addr_o is 0 (default variant).
- R11: cmd_end_i while waiting for a request closes the command. In the next cycle addr_o follows pio_addr_i again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_go_i | input | 1 | Opens a command (one-cycle pulse) |
| cmd_end_i | input | 1 | Closes the command while no burst is granted |
| mode_i | input | 3 | Transfer mode number, captured at command start |
| dev_req_i | input | 1 | Device burst request, active high |
| pause_i | input | 1 | Local request to pause the burst |
| end_i | input | 1 | Local request to end the burst |
| strobe_i | input | 1 | Device data strobe, asynchronous |
| data_i | input | 16 | Device data bus |
| pio_addr_i | input | 3 | Address used outside a command |
| pio_sel_n_i | input | 2 | Chip selects used outside a burst |
| ack_n_o | output | 1 | Burst acknowledge, active low |
| stop_o | output | 1 | Stop line, active high |
| rdy_n_o | output | 1 | Host ready, active low |
| addr_o | output | 3 | Address lines |
| sel_n_o | output | 2 | Chip selects, active low |
| word_valid_o | output | 1 | Received word strobe |
| word_o | output | 16 | Received word |
| overrun_o | output | 1 | Sticky pause allowance overflow |

## Verification
The bench presses pause and end requests during the armed window. A design that let them through would raise stop or drop ready before the first strobe edge. It sends two consecutive strobe changes in opposite directions, so a design that captured on only one edge loses every second word. It sends words through a pause in a low mode and in a high mode. A design that sized the allowance wrongly either flags the last legal word or quietly passes the surplus one. The bench ends bursts from the local side and from the device side and checks the stop-then-release order, then reopens a command to confirm the overflow flag clears only at that point.

// File: rtl/bic_pkg.sv
package bic_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_REQ,
      ST_ACK,
      ST_ARMED,
      ST_XFER,
      ST_PAUSE,
      ST_TERM
   } bic_state_e;

   function automatic logic grant_held(input bic_state_e s);
      return (s == ST_ACK) || (s == ST_ARMED) || (s == ST_XFER) ||
             (s == ST_PAUSE) || (s == ST_TERM);
   endfunction

   function automatic logic path_open(input bic_state_e s);
      return (s == ST_ARMED) || (s == ST_XFER) || (s == ST_PAUSE);
   endfunction

endpackage

// File: rtl/bic_strobe_sync.sv
module bic_strobe_sync #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              strobe_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              edge_o,
   output logic [DATA_W-1:0] word_o
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] stb_q;
   logic [DATA_W-1:0]      dat_q [SYNC_STAGES];
   logic                   hist_q;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  stb_q[0] <= 1'b0;
                  dat_q[0] <= '0;
               end else begin
                  stb_q[0] <= strobe_i;
                  dat_q[0] <= data_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  stb_q[i] <= 1'b0;
                  dat_q[i] <= '0;
               end else begin
                  stb_q[i] <= stb_q[i-1];
                  dat_q[i] <= dat_q[i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= 1'b0;
      else         hist_q <= stb_q[LAST];
   end

   assign edge_o = stb_q[LAST] ^ hist_q;
   assign word_o = dat_q[LAST];

endmodule

// File: rtl/bic_pause_budget.sv
module bic_pause_budget #(
   parameter int CNT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_cnt_i,
   input  logic             clr_flag_i,
   input  logic             edge_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             accept_o,
   output logic             over_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             over_q;

   assign accept_o = (cnt_q < limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_cnt_i) begin
         cnt_q <= '0;
      end else if (edge_i && accept_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         over_q <= 1'b0;
      end else if (clr_flag_i) begin
         over_q <= 1'b0;
      end else if (!clr_cnt_i && edge_i && !accept_o) begin
         over_q <= 1'b1;
      end
   end

   assign over_o = over_q;

endmodule

// File: rtl/bic_bus_drive.sv
module bic_bus_drive #(
   parameter int ADDR_W    = 3,
   parameter int SEL_W     = 2,
   parameter bit ZERO_ADDR = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_start_i,
   input  logic              in_cmd_i,
   input  logic              in_burst_i,
   input  logic [ADDR_W-1:0] pio_addr_i,
   input  logic [SEL_W-1:0]  pio_sel_n_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SEL_W-1:0]  sel_n_o
);
   logic [ADDR_W-1:0] cmd_addr;

   generate
      if (ZERO_ADDR) begin : g_zero
         logic unused_zero;
         assign unused_zero = ^{clk_i, rst_ni, cmd_start_i};
         assign cmd_addr = '0;
      end else begin : g_hold
         logic [ADDR_W-1:0] held_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          held_q <= '0;
            else if (cmd_start_i) held_q <= pio_addr_i;
         end
         assign cmd_addr = held_q;
      end
   endgenerate

   assign addr_o  = in_cmd_i   ? cmd_addr : pio_addr_i;
   assign sel_n_o = in_burst_i ? '1       : pio_sel_n_i;

endmodule

// File: rtl/burst_init_ctrl.sv
module burst_init_ctrl
   import bic_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 3,
   parameter int SEL_W        = 2,
   parameter int MODE_W       = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int LOW_MODE_MAX = 2,
   parameter int LIMIT_LOW    = 2,
   parameter int LIMIT_HIGH   = 3,
   parameter bit ZERO_ADDR    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_go_i,
   input  logic              cmd_end_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              dev_req_i,
   input  logic              pause_i,
   input  logic              end_i,
   input  logic              strobe_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] pio_addr_i,
   input  logic [SEL_W-1:0]  pio_sel_n_i,
   output logic              ack_n_o,
   output logic              stop_o,
   output logic              rdy_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SEL_W-1:0]  sel_n_o,
   output logic              word_valid_o,
   output logic [DATA_W-1:0] word_o,
   output logic              overrun_o
);
   localparam int CNT_W = $clog2(LIMIT_HIGH + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (LIMIT_LOW < 1 || LIMIT_HIGH < LIMIT_LOW) begin : g_bad_limit
         $error("pause allowance limits out of order");
      end
      if (LOW_MODE_MAX >= (1 << MODE_W)) begin : g_bad_mode
         $error("LOW_MODE_MAX does not fit MODE_W");
      end
   endgenerate

   bic_state_e        state_q, state_d;
   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  limit;
   logic              sync_edge;
   logic [DATA_W-1:0] sync_word;
   logic              budget_ok;
   logic              cmd_start;
   logic              take_word;
   logic              valid_q;
   logic [DATA_W-1:0] word_q;

   assign cmd_start = (state_q == ST_IDLE) && cmd_go_i;

   bic_strobe_sync #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_i),
      .data_i   (data_i),
      .edge_o   (sync_edge),
      .word_o   (sync_word)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mode_q <= '0;
      else if (cmd_start) mode_q <= mode_i;
   end

   assign limit = (int'(mode_q) <= LOW_MODE_MAX) ? CNT_W'(LIMIT_LOW) : CNT_W'(LIMIT_HIGH);

   bic_pause_budget #(
      .CNT_W (CNT_W)
   ) u_budget (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_cnt_i  (state_q != ST_PAUSE),
      .clr_flag_i (cmd_start),
      .edge_i     (sync_edge),
      .limit_i    (limit),
      .accept_o   (budget_ok),
      .over_o     (overrun_o)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (cmd_go_i) state_d = ST_WAIT_REQ;
         ST_WAIT_REQ: begin
            if (dev_req_i)      state_d = ST_ACK;
            else if (cmd_end_i) state_d = ST_IDLE;
         end
         ST_ACK:      state_d = ST_ARMED;
         ST_ARMED:    if (sync_edge) state_d = ST_XFER;
         ST_XFER: begin
            if (end_i || !dev_req_i) state_d = ST_TERM;
            else if (pause_i)        state_d = ST_PAUSE;
         end
         ST_PAUSE: begin
            if (end_i || !dev_req_i) state_d = ST_TERM;
            else if (!pause_i)       state_d = ST_XFER;
         end
         ST_TERM:     state_d = ST_WAIT_REQ;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign ack_n_o = !grant_held(state_q);
   assign stop_o  = !path_open(state_q);
   assign rdy_n_o = !((state_q == ST_ARMED) || (state_q == ST_XFER));

   assign take_word = sync_edge &&
                      ((state_q == ST_ARMED) || (state_q == ST_XFER) ||
                       ((state_q == ST_PAUSE) && budget_ok));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         word_q  <= '0;
      end else begin
         valid_q <= take_word;
         if (take_word) word_q <= sync_word;
      end
   end

   assign word_valid_o = valid_q;
   assign word_o       = word_q;

   bic_bus_drive #(
      .ADDR_W    (ADDR_W),
      .SEL_W     (SEL_W),
      .ZERO_ADDR (ZERO_ADDR)
   ) u_bus (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_start_i (cmd_start),
      .in_cmd_i    (state_q != ST_IDLE),
      .in_burst_i  (grant_held(state_q)),
      .pio_addr_i  (pio_addr_i),
      .pio_sel_n_i (pio_sel_n_i),
      .addr_o      (addr_o),
      .sel_n_o     (sel_n_o)
   );

endmodule

// File: rtl/burst_init_ctrl_chk.sv
module burst_init_ctrl_chk
   import bic_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             dev_req_i,
   input logic             ack_n_o,
   input logic             stop_o,
   input logic             rdy_n_o,
   input logic [SEL_W-1:0] sel_n_o,
   input logic             overrun_o,
   input bic_state_e       state_q
);
   // R2
   req_before_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_n_o) |-> $past(dev_req_i));

   // R3
   arm_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_n_o) |=> (!stop_o && !rdy_n_o));

   // R4
   armed_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_ARMED) |=> (!stop_o && !rdy_n_o));

   // R7
   overrun_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(overrun_o) |-> ($past(state_q) == ST_PAUSE));

   // R8
   stop_before_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_n_o) |-> $past(stop_o));

   // R9
   sel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_n_o |-> (sel_n_o == '1));

endmodule

bind burst_init_ctrl burst_init_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .dev_req_i (dev_req_i),
   .ack_n_o   (ack_n_o),
   .stop_o    (stop_o),
   .rdy_n_o   (rdy_n_o),
   .sel_n_o   (sel_n_o),
   .overrun_o (overrun_o),
   .state_q   (state_q)
);

// File: tb/burst_init_ctrl_bench.sv
module burst_init_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        cmd_go_i, cmd_end_i, dev_req_i, pause_i, end_i, strobe_i;
   logic [2:0]  mode_i, pio_addr_i, addr_o;
   logic [15:0] data_i, word_o;
   logic [1:0]  pio_sel_n_i, sel_n_o;
   logic        ack_n_o, stop_o, rdy_n_o, word_valid_o, overrun_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;
   logic [15:0] exp_q [$];

   always #(CLK_PERIOD / 2) clk_i = ~clk_i;

   burst_init_ctrl u_burst_init_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .cmd_go_i(cmd_go_i), .cmd_end_i(cmd_end_i),
      .mode_i(mode_i), .dev_req_i(dev_req_i), .pause_i(pause_i), .end_i(end_i),
      .strobe_i(strobe_i), .data_i(data_i), .pio_addr_i(pio_addr_i),
      .pio_sel_n_i(pio_sel_n_i), .ack_n_o(ack_n_o), .stop_o(stop_o),
      .rdy_n_o(rdy_n_o), .addr_o(addr_o), .sel_n_o(sel_n_o),
      .word_valid_o(word_valid_o), .word_o(word_o), .overrun_o(overrun_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_i);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // driver: one strobe change carries one word; expected words go to the queue
   task automatic send_word(input logic [15:0] w, input bit expect_it);
      data_i   = w;
      strobe_i = ~strobe_i;
      if (expect_it) exp_q.push_back(w);
      repeat (4) tick();
   endtask

   // monitor / scoreboard (R5)
   initial begin
      forever begin
         @(posedge clk_i);
         #2;
         if (rst_ni && word_valid_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected word", int'(word_o), 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check(word_o == e, "R5 word order", int'(word_o), int'(e));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      check(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      rst_ni = 1'b0; cmd_go_i = 0; cmd_end_i = 0; dev_req_i = 0; pause_i = 0;
      end_i = 0; strobe_i = 0; data_i = '0; mode_i = 3'd1;
      pio_addr_i = 3'b101; pio_sel_n_i = 2'b10;
      repeat (3) tick();
      check(ack_n_o && stop_o && rdy_n_o && !word_valid_o && !overrun_o,
            "R1 reset outputs", {ack_n_o, stop_o, rdy_n_o, word_valid_o, overrun_o}, 5'b11100);
      rst_ni = 1'b1;
      tick();
      check(addr_o == pio_addr_i && sel_n_o == pio_sel_n_i, "R1 passthrough",
            {addr_o, sel_n_o}, {pio_addr_i, pio_sel_n_i});

      // open command, mode 1
      cmd_go_i = 1; tick(); cmd_go_i = 0;
      check(addr_o == 3'b000, "R10 address zero", addr_o, 0);
      for (int i = 0; i < 4; i++) begin
         check(ack_n_o == 1'b1, "R2 no ack without request", ack_n_o, 1);
         tick();
      end
      dev_req_i = 1; tick();
      check(!ack_n_o && stop_o && rdy_n_o, "R2 grant", {ack_n_o, stop_o, rdy_n_o}, 3'b011);
      check(sel_n_o == 2'b11, "R9 selects negated", sel_n_o, 3);
      tick();
      check(!stop_o && !rdy_n_o, "R3 armed", {stop_o, rdy_n_o}, 0);
      pause_i = 1; end_i = 1;
      for (int i = 0; i < 3; i++) begin
         tick();
         check(!stop_o && !rdy_n_o, "R4 locked until first edge", {stop_o, rdy_n_o}, 0);
      end
      pause_i = 0; end_i = 0;
      send_word(16'hA5A1, 1'b1);
      send_word(16'h5A02, 1'b1);
      send_word(16'hC303, 1'b1);
      check(exp_q.size() == 0, "R5 both edges delivered", exp_q.size(), 0);

      pause_i = 1; tick();
      check(rdy_n_o && !stop_o, "R6 pause drops ready", {rdy_n_o, stop_o}, 2'b10);
      send_word(16'h1111, 1'b1);
      send_word(16'h2222, 1'b1);
      check(!overrun_o, "R7 low mode allowance 2 ok", overrun_o, 0);
      send_word(16'h3333, 1'b0);
      check(overrun_o, "R7 low mode overflow", overrun_o, 1);
      pause_i = 0; tick();
      check(!rdy_n_o && !stop_o, "R6 resume", {rdy_n_o, stop_o}, 0);
      send_word(16'h4444, 1'b1);

      end_i = 1; dev_req_i = 0; tick(); end_i = 0;
      check(stop_o && !ack_n_o, "R8 stop first", {stop_o, ack_n_o}, 2'b10);
      tick();
      check(ack_n_o && rdy_n_o, "R8 release", {ack_n_o, rdy_n_o}, 2'b11);
      check(sel_n_o == pio_sel_n_i, "R9 selects restored", sel_n_o, pio_sel_n_i);
      check(overrun_o, "R7 sticky", overrun_o, 1);
      cmd_end_i = 1; tick(); cmd_end_i = 0;
      check(addr_o == pio_addr_i, "R11 command closed", addr_o, pio_addr_i);

      // second command, mode 4
      mode_i = 3'd4; cmd_go_i = 1; tick(); cmd_go_i = 0;
      check(!overrun_o, "R7 cleared at start", overrun_o, 0);
      dev_req_i = 1; tick(); tick();
      send_word(16'hBEEF, 1'b1);
      pause_i = 1; tick();
      send_word(16'h0A0A, 1'b1);
      send_word(16'h0B0B, 1'b1);
      send_word(16'h0C0C, 1'b1);
      check(!overrun_o, "R7 high mode allowance 3 ok", overrun_o, 0);
      send_word(16'h0D0D, 1'b0);
      check(overrun_o, "R7 high mode overflow", overrun_o, 1);
      dev_req_i = 0; tick();
      check(stop_o && !ack_n_o, "R8 device ends burst", {stop_o, ack_n_o}, 2'b10);
      tick();
      check(ack_n_o, "R8 device end release", ack_n_o, 1);
      pause_i = 0;
      repeat (5) tick();
      check(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
      report();
   end

endmodule